// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves the processor out of Run and into one of three low-power states when the core executes a wait instruction. The wait may be a wait-for-interrupt or a wait-for-event strobe. Two configuration bits choose the state:

- **Sleep** stops only the CPU clock.
- **Deep-sleep** stops every core-domain clock and shuts down the high-frequency oscillators. It may also put the regulator into its low-power or low-drive setting.
- **Standby** switches off the core power domain and the regulator, and places the I/O pads in high impedance.

While asleep, the sequencer watches only the wakeup sources that are valid for the current state and for the kind of wait that was executed. Leaving Sleep takes one clock edge. Leaving Deep-sleep first counts out the regulator recovery, if the regulator was in low-power mode, and then the oscillator startup, before the clocks are released. Leaving Standby raises a one-cycle power-on reset request, after which the core restarts from its boot vector.

A one-bit event latch records events that arrive while running. A wait-for-event issued with the latch set consumes the latch and does not sleep.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in Run. In Run, lpMode=0, both clock-off outputs are 0, oscRun=1, regEn=1, coreDomainOn=1, porReq=0 and ioHiZ is all zero.
- R2: A wait request with cfgDeep=0 enters Sleep whatever cfgStandby is. Sleep reports lpMode=1 with cpuClkOff=1, coreClkOff=0 and oscRun=1.
- R3: A wait request with cfgDeep=1 and cfgStandby=0 enters Deep-sleep, with lpMode=2, coreClkOff=1 and oscRun=0. In this state regLowPwr and regLowDrive equal the configuration values captured at entry.
- R4: A wait request with cfgDeep=1 and cfgStandby=1 enters Standby, with lpMode=3, coreDomainOn=0, regEn=0 and oscRun=0.
- R5: Sleep entered through waitIrqReq returns to Run on the first edge that samples irqPend or any extIrq line. Event inputs alone do not wake it.
- R6: Sleep entered through waitEvtReq wakes on the first edge that samples evtIn or any extEvt line. irqPend or extIrq wake it only when cfgSevOnPend=1.
- R7: Deep-sleep ignores irqPend and evtIn. After waitIrqReq entry it wakes on any extIrq line. After waitEvtReq entry it wakes on any extEvt line, or on extIrq when cfgSevOnPend=1.
- R8: Standby wakes only on rstPinWake, wdgRstWake, rtcAlarm, or wakePin while cfgWakePinEn=1. Every other input leaves it in Standby.
- R9: Leaving Standby produces exactly one cycle with porReq=1, then Run. The event latch is cleared.
- R10: Leaving Deep-sleep re-enables the oscillators on the edge that samples the wake source. Run is reached OSC_CYC+2 edges after that sample, counting the sampling edge, plus REG_CYC more when regLowPwr was captured as 1.
- R11: In Standby, every ioHiZ bit is 1 except the exempt ones. Bit 0 (reset pin) is never set. Bit 1 is clear when cfgRtcPin=1. Bits 2 and 3 are clear when cfgLxtalOn=1. Bit 4 is clear when cfgWakePinEn=1. Outside Standby, ioHiZ is zero.
- R12: evtIn sampled in Run sets the event latch. A waitEvtReq that finds the latch set clears it and stays in Run. Any waitEvtReq clears the latch.
- R13: regLowPwr and regLowDrive read 0 in Run, in Sleep and during Deep-sleep recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgDeep | input | 1 | Selects Deep-sleep or Standby over Sleep |
| cfgStandby | input | 1 | Selects Standby when cfgDeep is set |
| cfgSevOnPend | input | 1 | Lets pending interrupts wake an event wait |
| cfgRegLowPwr | input | 1 | Regulator low-power request for Deep-sleep |
| cfgRegLowDrive | input | 1 | Regulator low-drive request for Deep-sleep |
| cfgRtcPin | input | 1 | RTC function owns its pad |
| cfgLxtalOn | input | 1 | Low-speed crystal owns its two pads |
| cfgWakePinEn | input | 1 | Wakeup pin enabled |
| waitIrqReq | input | 1 | Wait-for-interrupt strobe |
| waitEvtReq | input | 1 | Wait-for-event strobe |
| irqPend | input | 1 | Any peripheral interrupt pending |
| evtIn | input | 1 | Event pulse |
| extIrq | input | N_EXT | External controller interrupt lines |
| extEvt | input | N_EXT | External controller event lines |
| rstPinWake | input | 1 | Reset pin activity |
| wakePin | input | 1 | Wakeup pin level |
| wdgRstWake | input | 1 | Independent watchdog reset |
| rtcAlarm | input | 1 | RTC alarm |
| cpuClkOff | output | 1 | CPU clock gated |
| coreClkOff | output | 1 | All core-domain clocks gated |
| oscRun | output | 1 | RC oscillator, crystal and PLL enabled |
| regEn | output | 1 | Regulator on |
| regLowPwr | output | 1 | Regulator in low-power mode |
| regLowDrive | output | 1 | Regulator in low-drive mode |
| coreDomainOn | output | 1 | Core power domain supplied |
| porReq | output | 1 | Power-on reset request |
| lpMode | output | 2 | 0 Run, 1 Sleep, 2 Deep-sleep, 3 Standby |
| ioHiZ | output | N_IO | Per-pad high-impedance enable |

## Verification
The hardest situation to reach is one where a wake source arrives that is valid for some other state or wait kind, but not for the current one. This matters most for the interplay of cfgSevOnPend with the entry type. The bench sweeps every state, both entry strobes and both cfgSevOnPend values. In each case it applies each candidate source on its own for one cycle, and it predicts wake or no wake from a table built from the requirements.

The Deep-sleep recovery length is measured in edges with and without the regulator low-power capture. The event-latch shortcut is reached by pulsing evtIn in Run before a wait-for-event. Standby pad masking is swept over all eight exemption settings.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    S_RUN,
    S_SLEEP,
    S_DEEP,
    S_DWAKE,
    S_STBY,
    S_POR
  } lpmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTimers;
    logic captureReg;
    logic clrEvt;
  } seqCmd_t;

  // pad positions with Standby exemptions
  localparam int IO_RST = 0;
  localparam int IO_RTC = 1;
  localparam int IO_LX0 = 2;
  localparam int IO_LX1 = 3;
  localparam int IO_WK  = 4;

endpackage

// File: rtl/pwr_mode_seq_dp.sv
module pwr_mode_seq_dp
  import pwr_mode_pkg::*;
#(
  parameter int OSC_CYC = 16,
  parameter int REG_CYC = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  seqCmd_t cmd,
  input  logic    inRun,
  input  logic    evtIn,
  input  logic    cfgRegLowPwr,
  input  logic    cfgRegLowDrive,
  output logic    timersDone,
  output logic    evtLatched,
  output logic    regLpSel,
  output logic    regLdSel
);

  localparam int MAXC = (OSC_CYC > REG_CYC) ? OSC_CYC : REG_CYC;
  localparam int CW   = $clog2(MAXC + 2);

  logic [CW-1:0] oscCnt;
  logic [CW-1:0] regCnt;

  // regulator recovery counts first, oscillator startup afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscCnt <= '0;
      regCnt <= '0;
    end else if (cmd.loadTimers) begin
      oscCnt <= CW'(OSC_CYC);
      regCnt <= regLpSel ? CW'(REG_CYC) : '0;
    end else if (regCnt != '0) begin
      regCnt <= regCnt - CW'(1);
    end else if (oscCnt != '0) begin
      oscCnt <= oscCnt - CW'(1);
    end
  end

  assign timersDone = (oscCnt == '0) && (regCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regLpSel <= 1'b0;
      regLdSel <= 1'b0;
    end else if (cmd.captureReg) begin
      regLpSel <= cfgRegLowPwr;
      regLdSel <= cfgRegLowDrive;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtLatched <= 1'b0;
    end else if (cmd.clrEvt) begin
      evtLatched <= 1'b0;
    end else if (inRun && evtIn) begin
      evtLatched <= 1'b1;
    end
  end

endmodule

// File: rtl/pwr_mode_seq_ctl.sv
module pwr_mode_seq_ctl
  import pwr_mode_pkg::*;
#(
  parameter int N_EXT = 4,
  parameter int N_IO  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgDeep,
  input  logic             cfgStandby,
  input  logic             cfgSevOnPend,
  input  logic             cfgRtcPin,
  input  logic             cfgLxtalOn,
  input  logic             cfgWakePinEn,
  input  logic             waitIrqReq,
  input  logic             waitEvtReq,
  input  logic             irqPend,
  input  logic             evtIn,
  input  logic [N_EXT-1:0] extIrq,
  input  logic [N_EXT-1:0] extEvt,
  input  logic             rstPinWake,
  input  logic             wakePin,
  input  logic             wdgRstWake,
  input  logic             rtcAlarm,
  input  logic             timersDone,
  input  logic             evtLatched,
  input  logic             regLpSel,
  input  logic             regLdSel,
  output seqCmd_t          cmd,
  output logic             inRun,
  output logic             cpuClkOff,
  output logic             coreClkOff,
  output logic             oscRun,
  output logic             regEn,
  output logic             regLowPwr,
  output logic             regLowDrive,
  output logic             coreDomainOn,
  output logic             porReq,
  output logic [1:0]       lpMode,
  output logic [N_IO-1:0]  ioHiZ
);

  lpmState_t stateQ, stateD, targetMode;
  logic entryEvtQ;
  logic anyXi, anyXe, sleepWake, deepWake, stbyWake, inStby;

  assign anyXi = |extIrq;
  assign anyXe = |extEvt;

  assign targetMode = !cfgDeep ? S_SLEEP : (cfgStandby ? S_STBY : S_DEEP);

  assign sleepWake = entryEvtQ ? (evtIn | anyXe | (cfgSevOnPend & (irqPend | anyXi)))
                               : (irqPend | anyXi);
  assign deepWake  = entryEvtQ ? (anyXe | (cfgSevOnPend & anyXi)) : anyXi;
  assign stbyWake  = rstPinWake | (wakePin & cfgWakePinEn) | wdgRstWake | rtcAlarm;

  always_comb begin
    stateD = stateQ;
    cmd    = '0;
    unique case (stateQ)
      S_RUN: begin
        if (waitIrqReq) begin
          stateD         = targetMode;
          cmd.captureReg = 1'b1;
        end else if (waitEvtReq) begin
          cmd.clrEvt = 1'b1;
          if (!evtLatched) begin
            stateD         = targetMode;
            cmd.captureReg = 1'b1;
          end
        end
      end
      S_SLEEP: if (sleepWake) stateD = S_RUN;
      S_DEEP: begin
        if (deepWake) begin
          stateD         = S_DWAKE;
          cmd.loadTimers = 1'b1;
        end
      end
      S_DWAKE: if (timersDone) stateD = S_RUN;
      S_STBY:  if (stbyWake) stateD = S_POR;
      S_POR: begin
        stateD     = S_RUN;
        cmd.clrEvt = 1'b1;
      end
      default: stateD = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= S_RUN;
      entryEvtQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == S_RUN && (waitIrqReq || waitEvtReq)) entryEvtQ <= !waitIrqReq;
    end
  end

  assign inRun        = (stateQ == S_RUN);
  assign inStby       = (stateQ == S_STBY);
  assign cpuClkOff    = !inRun;
  assign coreClkOff   = (stateQ == S_DEEP) || (stateQ == S_DWAKE) || inStby || (stateQ == S_POR);
  assign oscRun       = !((stateQ == S_DEEP) || inStby);
  assign regEn        = !inStby;
  assign coreDomainOn = !inStby;
  assign regLowPwr    = (stateQ == S_DEEP) && regLpSel;
  assign regLowDrive  = (stateQ == S_DEEP) && regLdSel;
  assign porReq       = (stateQ == S_POR);

  always_comb begin
    unique case (stateQ)
      S_SLEEP:         lpMode = 2'd1;
      S_DEEP, S_DWAKE: lpMode = 2'd2;
      S_STBY, S_POR:   lpMode = 2'd3;
      default:         lpMode = 2'd0;
    endcase
  end

  for (genvar i = 0; i < N_IO; i++) begin : g_pad
    if (i == IO_RST) begin : g_rst
      assign ioHiZ[i] = 1'b0;
    end else if (i == IO_RTC) begin : g_rtc
      assign ioHiZ[i] = inStby & !cfgRtcPin;
    end else if (i == IO_LX0 || i == IO_LX1) begin : g_lx
      assign ioHiZ[i] = inStby & !cfgLxtalOn;
    end else if (i == IO_WK) begin : g_wk
      assign ioHiZ[i] = inStby & !cfgWakePinEn;
    end else begin : g_gen
      assign ioHiZ[i] = inStby;
    end
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int N_EXT   = 4,
  parameter int N_IO    = 8,
  parameter int OSC_CYC = 16,
  parameter int REG_CYC = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgDeep,
  input  logic             cfgStandby,
  input  logic             cfgSevOnPend,
  input  logic             cfgRegLowPwr,
  input  logic             cfgRegLowDrive,
  input  logic             cfgRtcPin,
  input  logic             cfgLxtalOn,
  input  logic             cfgWakePinEn,
  input  logic             waitIrqReq,
  input  logic             waitEvtReq,
  input  logic             irqPend,
  input  logic             evtIn,
  input  logic [N_EXT-1:0] extIrq,
  input  logic [N_EXT-1:0] extEvt,
  input  logic             rstPinWake,
  input  logic             wakePin,
  input  logic             wdgRstWake,
  input  logic             rtcAlarm,
  output logic             cpuClkOff,
  output logic             coreClkOff,
  output logic             oscRun,
  output logic             regEn,
  output logic             regLowPwr,
  output logic             regLowDrive,
  output logic             coreDomainOn,
  output logic             porReq,
  output logic [1:0]       lpMode,
  output logic [N_IO-1:0]  ioHiZ
);

  seqCmd_t cmd;
  logic inRun, timersDone, evtLatched, regLpSel, regLdSel;

  pwr_mode_seq_ctl #(.N_EXT(N_EXT), .N_IO(N_IO)) ctl_i (
    .clk(clk), .rstN(rstN),
    .cfgDeep(cfgDeep), .cfgStandby(cfgStandby), .cfgSevOnPend(cfgSevOnPend),
    .cfgRtcPin(cfgRtcPin), .cfgLxtalOn(cfgLxtalOn), .cfgWakePinEn(cfgWakePinEn),
    .waitIrqReq(waitIrqReq), .waitEvtReq(waitEvtReq),
    .irqPend(irqPend), .evtIn(evtIn), .extIrq(extIrq), .extEvt(extEvt),
    .rstPinWake(rstPinWake), .wakePin(wakePin), .wdgRstWake(wdgRstWake), .rtcAlarm(rtcAlarm),
    .timersDone(timersDone), .evtLatched(evtLatched),
    .regLpSel(regLpSel), .regLdSel(regLdSel),
    .cmd(cmd), .inRun(inRun),
    .cpuClkOff(cpuClkOff), .coreClkOff(coreClkOff), .oscRun(oscRun), .regEn(regEn),
    .regLowPwr(regLowPwr), .regLowDrive(regLowDrive), .coreDomainOn(coreDomainOn),
    .porReq(porReq), .lpMode(lpMode), .ioHiZ(ioHiZ)
  );

  pwr_mode_seq_dp #(.OSC_CYC(OSC_CYC), .REG_CYC(REG_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inRun(inRun), .evtIn(evtIn),
    .cfgRegLowPwr(cfgRegLowPwr), .cfgRegLowDrive(cfgRegLowDrive),
    .timersDone(timersDone), .evtLatched(evtLatched),
    .regLpSel(regLpSel), .regLdSel(regLdSel)
  );

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int N_EXT = 4,
  parameter int N_IO  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [N_EXT-1:0] extIrq,
  input logic [N_EXT-1:0] extEvt,
  input logic             cpuClkOff,
  input logic             coreClkOff,
  input logic             oscRun,
  input logic             regEn,
  input logic             regLowPwr,
  input logic             regLowDrive,
  input logic             coreDomainOn,
  input logic             porReq,
  input logic [1:0]       lpMode,
  input logic [N_IO-1:0]  ioHiZ
);

  a_r2_sleep_clocks: assert property (@(posedge clk) disable iff (!rstN)
    lpMode == 2'd1 |-> cpuClkOff && !coreClkOff && oscRun);

  a_r4_stby_unpowered: assert property (@(posedge clk) disable iff (!rstN)
    (lpMode == 2'd3 && !porReq) |-> !coreDomainOn && !regEn && !oscRun);

  a_r7_deep_holds: assert property (@(posedge clk) disable iff (!rstN)
    (lpMode == 2'd2 && !oscRun && extIrq == '0 && extEvt == '0) |=> (lpMode == 2'd2 && !oscRun));

  a_r9_por_single: assert property (@(posedge clk) disable iff (!rstN)
    porReq |=> !porReq && lpMode == 2'd0);

  a_r11_rst_pad_live: assert property (@(posedge clk) disable iff (!rstN)
    !ioHiZ[0]);

  a_r11_hiz_only_stby: assert property (@(posedge clk) disable iff (!rstN)
    (ioHiZ != '0) |-> (lpMode == 2'd3 && !coreDomainOn));

  a_r13_reg_normal: assert property (@(posedge clk) disable iff (!rstN)
    (lpMode < 2'd2 || oscRun) |-> !regLowPwr && !regLowDrive);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.N_EXT(N_EXT), .N_IO(N_IO)) chk_i (
  .clk(clk), .rstN(rstN), .extIrq(extIrq), .extEvt(extEvt),
  .cpuClkOff(cpuClkOff), .coreClkOff(coreClkOff), .oscRun(oscRun), .regEn(regEn),
  .regLowPwr(regLowPwr), .regLowDrive(regLowDrive), .coreDomainOn(coreDomainOn),
  .porReq(porReq), .lpMode(lpMode), .ioHiZ(ioHiZ)
);

// File: tb/pwr_mode_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_seq_tb_top;

  localparam int N_EXT   = 4;
  localparam int N_IO    = 8;
  localparam int OSC_CYC = 6;
  localparam int REG_CYC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgDeep = 0, cfgStandby = 0, cfgSevOnPend = 0, cfgRegLowPwr = 0, cfgRegLowDrive = 0;
  logic cfgRtcPin = 0, cfgLxtalOn = 0, cfgWakePinEn = 1;
  logic waitIrqReq = 0, waitEvtReq = 0, irqPend = 0, evtIn = 0;
  logic [N_EXT-1:0] extIrq = '0, extEvt = '0;
  logic rstPinWake = 0, wakePin = 0, wdgRstWake = 0, rtcAlarm = 0;
  logic cpuClkOff, coreClkOff, oscRun, regEn, regLowPwr, regLowDrive, coreDomainOn, porReq;
  logic [1:0] lpMode;
  logic [N_IO-1:0] ioHiZ;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pwr_mode_seq #(.N_EXT(N_EXT), .N_IO(N_IO), .OSC_CYC(OSC_CYC), .REG_CYC(REG_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .cfgDeep(cfgDeep), .cfgStandby(cfgStandby),
    .cfgSevOnPend(cfgSevOnPend), .cfgRegLowPwr(cfgRegLowPwr), .cfgRegLowDrive(cfgRegLowDrive),
    .cfgRtcPin(cfgRtcPin), .cfgLxtalOn(cfgLxtalOn), .cfgWakePinEn(cfgWakePinEn),
    .waitIrqReq(waitIrqReq), .waitEvtReq(waitEvtReq), .irqPend(irqPend), .evtIn(evtIn),
    .extIrq(extIrq), .extEvt(extEvt), .rstPinWake(rstPinWake), .wakePin(wakePin),
    .wdgRstWake(wdgRstWake), .rtcAlarm(rtcAlarm),
    .cpuClkOff(cpuClkOff), .coreClkOff(coreClkOff), .oscRun(oscRun), .regEn(regEn),
    .regLowPwr(regLowPwr), .regLowDrive(regLowDrive), .coreDomainOn(coreDomainOn),
    .porReq(porReq), .lpMode(lpMode), .ioHiZ(ioHiZ)
  );

  task automatic checkEq(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  // m: 1 Sleep, 2 Deep-sleep, 3 Standby
  task automatic enterMode(int m, bit viaEvt);
    @(negedge clk);
    cfgDeep    = (m != 1);
    cfgStandby = (m == 3);
    if (viaEvt) waitEvtReq = 1'b1; else waitIrqReq = 1'b1;
    @(negedge clk);
    waitEvtReq = 1'b0;
    waitIrqReq = 1'b0;
  endtask

  task automatic setSrc(int k, bit v);
    case (k)
      0: irqPend = v;
      1: evtIn = v;
      2: extIrq[0] = v;
      3: extIrq[N_EXT-1] = v;
      4: extEvt[0] = v;
      5: rstPinWake = v;
      6: wakePin = v;
      7: begin wakePin = v; cfgWakePinEn = !v; end
      8: wdgRstWake = v;
      default: rtcAlarm = v;
    endcase
  endtask

  function automatic bit expWake(int m, bit ev, bit sev, int k);
    bit irq = (k == 0);
    bit evp = (k == 1);
    bit xi  = (k == 2) || (k == 3);
    bit xe  = (k == 4);
    bit sb  = (k == 5) || (k == 6) || (k == 8) || (k == 9);
    case (m)
      1: return ev ? (evp | xe | (sev & (irq | xi))) : (irq | xi);
      2: return ev ? (xe | (sev & xi)) : xi;
      default: return sb;
    endcase
  endfunction

  task automatic waitRun(string req);
    int n = 0;
    while (lpMode != 2'd0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    checkEq(req, "return to Run", lpMode, 0);
  endtask

  task automatic wakeAny();
    extIrq[0] = 1'b1; extEvt[0] = 1'b1; rtcAlarm = 1'b1;
    @(negedge clk);
    extIrq[0] = 1'b0; extEvt[0] = 1'b0; rtcAlarm = 1'b0;
    waitRun("R5");
  endtask

  initial begin
    string tag;
    logic [N_IO-1:0] expHiZ;
    int edges;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1", "lpMode", lpMode, 0);
    checkEq("R1", "cpuClkOff", cpuClkOff, 0);
    checkEq("R1", "coreClkOff", coreClkOff, 0);
    checkEq("R1", "oscRun", oscRun, 1);
    checkEq("R1", "regEn", regEn, 1);
    checkEq("R1", "coreDomainOn", coreDomainOn, 1);
    checkEq("R1", "porReq", porReq, 0);
    checkEq("R1", "ioHiZ", ioHiZ, 0);

    // wake-source sweep over state, entry kind and send-on-pending
    for (int m = 1; m <= 3; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int s = 0; s < 2; s++) begin
          cfgSevOnPend = s[0];
          tag = (m == 1) ? (e ? "R6" : "R5") : ((m == 2) ? "R7" : "R8");
          enterMode(m, e[0]);
          checkEq(m == 1 ? "R2" : (m == 2 ? "R3" : "R4"), "lpMode entry", lpMode, m);
          if (m == 1) begin
            checkEq("R2", "cpuClkOff", cpuClkOff, 1);
            checkEq("R2", "coreClkOff", coreClkOff, 0);
            checkEq("R2", "oscRun", oscRun, 1);
          end else if (m == 2) begin
            checkEq("R3", "coreClkOff", coreClkOff, 1);
            checkEq("R3", "oscRun", oscRun, 0);
          end else begin
            checkEq("R4", "coreDomainOn", coreDomainOn, 0);
            checkEq("R4", "regEn", regEn, 0);
            checkEq("R4", "oscRun", oscRun, 0);
          end
          for (int k = 0; k < 10; k++) begin
            setSrc(k, 1'b1);
            @(negedge clk);
            setSrc(k, 1'b0);
            if (!expWake(m, e[0], s[0], k)) begin
              checkEq(tag, $sformatf("stay asleep src %0d", k), lpMode, m);
            end else begin
              if (m == 1) begin
                checkEq(tag, $sformatf("wake src %0d", k), lpMode, 0);
              end else if (m == 2) begin
                checkEq("R10", "oscillators back on", oscRun, 1);
                checkEq("R10", "clocks still off", coreClkOff, 1);
                waitRun(tag);
              end else begin
                checkEq("R9", "porReq pulse", porReq, 1);
                @(negedge clk);
                checkEq("R9", "porReq drops", porReq, 0);
                checkEq("R9", "Run after reset request", lpMode, 0);
              end
              enterMode(m, e[0]);
            end
          end
          wakeAny();
        end
      end
    end
    cfgSevOnPend = 1'b0;

    // R10 Deep-sleep recovery length, R3/R13 regulator selections
    for (int lp = 0; lp < 2; lp++) begin
      cfgRegLowPwr = lp[0];
      cfgRegLowDrive = lp[0];
      enterMode(2, 1'b0);
      checkEq("R3", "regLowPwr captured", regLowPwr, lp);
      checkEq("R3", "regLowDrive captured", regLowDrive, lp);
      extIrq[1] = 1'b1;
      edges = 0;
      @(posedge clk);
      edges++;
      @(negedge clk);
      extIrq[1] = 1'b0;
      checkEq("R13", "regLowPwr in recovery", regLowPwr, 0);
      while (coreClkOff && edges < 100) begin
        @(posedge clk);
        edges++;
        @(negedge clk);
      end
      checkEq("R10", "recovery edges", edges, OSC_CYC + (lp ? REG_CYC : 0) + 2);
      checkEq("R13", "regLowPwr in Run", regLowPwr, 0);
    end

    // R13 Sleep keeps the regulator normal; R2 standby bit ignored without deep
    @(negedge clk);
    cfgDeep = 1'b0; cfgStandby = 1'b1; waitIrqReq = 1'b1;
    @(negedge clk);
    waitIrqReq = 1'b0;
    checkEq("R2", "Sleep despite standby bit", lpMode, 1);
    checkEq("R13", "regLowPwr in Sleep", regLowPwr, 0);
    checkEq("R13", "regLowDrive in Sleep", regLowDrive, 0);
    irqPend = 1'b1;
    @(negedge clk);
    irqPend = 1'b0;
    checkEq("R5", "irq wake", lpMode, 0);
    cfgRegLowPwr = 1'b0; cfgRegLowDrive = 1'b0;

    // R11 pad masking over all exemption settings
    for (int c = 0; c < 8; c++) begin
      cfgRtcPin = c[0]; cfgLxtalOn = c[1]; cfgWakePinEn = c[2];
      expHiZ = '1;
      expHiZ[0] = 1'b0;
      if (c[0]) expHiZ[1] = 1'b0;
      if (c[1]) begin expHiZ[2] = 1'b0; expHiZ[3] = 1'b0; end
      if (c[2]) expHiZ[4] = 1'b0;
      enterMode(3, 1'b0);
      checkEq("R11", $sformatf("ioHiZ cfg %0d", c), ioHiZ, expHiZ);
      rtcAlarm = 1'b1;
      @(negedge clk);
      rtcAlarm = 1'b0;
      checkEq("R11", "ioHiZ during reset request", ioHiZ, 0);
      waitRun("R9");
      checkEq("R11", "ioHiZ in Run", ioHiZ, 0);
    end
    cfgRtcPin = 1'b0; cfgLxtalOn = 1'b0; cfgWakePinEn = 1'b1;

    // R12 latched event short-circuits the wait
    @(negedge clk);
    evtIn = 1'b1;
    @(negedge clk);
    evtIn = 1'b0;
    enterMode(1, 1'b1);
    checkEq("R12", "latched event keeps Run", lpMode, 0);
    enterMode(1, 1'b1);
    checkEq("R12", "latch consumed, Sleep entered", lpMode, 1);
    evtIn = 1'b1;
    @(negedge clk);
    evtIn = 1'b0;
    checkEq("R6", "event wake", lpMode, 0);

    // R9 Standby exit clears the latch
    evtIn = 1'b1;
    @(negedge clk);
    evtIn = 1'b0;
    enterMode(3, 1'b0);
    wdgRstWake = 1'b1;
    @(negedge clk);
    wdgRstWake = 1'b0;
    waitRun("R9");
    enterMode(1, 1'b1);
    checkEq("R9", "latch cleared by reset request", lpMode, 1);
    wakeAny();

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule